// File: doc/BRIEF.md
# Prescaled PWM Generator with Commit-Latched Timing

This block produces a single pulse-width-modulated output from a fast input clock. A small register bank holds an enable, a prescaler value, a period count and a high-width count. Software writes the timing values into shadow registers, which have no effect on the waveform until software writes a 1 to a commit register. Software then clears the commit register again.

A 0-to-1 transition of the commit register captures the shadow set. The captured set becomes active at the next period boundary, so a period in progress always completes with the timing it started with. While the block is disabled, a captured set becomes active immediately. Each output period lasts (div+1)*(period+1) input clocks. The output is high for the first (div+1)*width of those clocks.

Top module: `shadowed_pwm`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is low.
- R2: Register map, byte addresses:
  - 0x0: enable in bit 0.
  - 0x4: commit in bit 0.
  - 0x8: divider in bits [9:0].
  - 0xC: period in bits [11:0] and width in bits [28:16].
  
  A read returns the last written value of the field. Unused bits and unmapped addresses read 0.
- R3: While enabled, the output repeats a cycle of (div+1)*(period+1) clocks. The output is high for the first (div+1)*width clocks of each cycle. The first cycle starts in the clock after enable is written.
- R4: Writes to divider, period or width leave the output unchanged while no commit rising edge follows them.
- R5: A write of commit bit 1 while commit reads 0 captures the shadow values. The captured values become active at the next period boundary. Writing 1 again while commit already reads 1 captures nothing.
- R6: With width 0 the output stays low for the whole enabled time.
- R7: With width at or above period+1 the output stays high for the whole enabled time.
- R8: Clearing enable drives the output low and holds both counters at zero. Setting enable again restarts at the beginning of a period.
- R9: A commit issued while the block is disabled is active by the time enable is next set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
Internal state in this block is visible at the pin quickly:
- A prescaler or period counter that runs past its limit stretches the waveform, and the sampled pattern drifts from the expected one within one period.
- A reload at the wrong moment truncates or stretches the period in which the commit arrives, so the error shows before the following period ends.
- A missed or spurious capture leaves the wrong high/low ratio for every later period.

The bench therefore compares `pwm_out` sample by sample against a pattern computed from the divider, period and width formulas. It does this across commits, repeated commits and disable/enable transitions.

// File: rtl/shadowed_pwm.sv
module shadowed_pwm #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int WID_W  = 13,
  parameter int WID_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);

  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_TIM = ADDR_W'(12);

  logic             en_q, cmt_q, pend;
  logic [DIV_W-1:0] sh_div, st_div, act_div, pre_cnt;
  logic [PER_W-1:0] sh_per, st_per, act_per, per_cnt;
  logic [WID_W-1:0] sh_wid, st_wid, act_wid;

  wire wr_cmt   = wr_en && addr == A_CMT;
  wire cmt_rise = wr_cmt && wr_data[0] && !cmt_q;
  wire tick     = pre_cnt == act_div;
  wire bnd      = tick && per_cnt == act_per;
  wire load     = pend && (!en_q || bnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cmt_q  <= 1'b0;
      sh_div <= '0;
      sh_per <= '0;
      sh_wid <= '0;
    end else if (wr_en) begin
      case (addr)
        A_EN:  en_q  <= wr_data[0];
        A_CMT: cmt_q <= wr_data[0];
        A_DIV: sh_div <= wr_data[DIV_W-1:0];
        A_TIM: begin
          sh_per <= wr_data[PER_W-1:0];
          sh_wid <= wr_data[WID_LSB +: WID_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      st_div <= '0;
      st_per <= '0;
      st_wid <= '0;
    end else if (cmt_rise) begin
      pend   <= 1'b1;
      st_div <= sh_div;
      st_per <= sh_per;
      st_wid <= sh_wid;
    end else if (load) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0;
      act_per <= '0;
      act_wid <= '0;
    end else if (load) begin
      act_div <= st_div;
      act_per <= st_per;
      act_wid <= st_wid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (!en_q) begin
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= bnd ? '0 : per_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign pwm_out = en_q && (WID_W'(per_cnt) < act_wid);

  always_comb begin
    rd_data = '0;
    case (addr)
      A_EN:  rd_data[0] = en_q;
      A_CMT: rd_data[0] = cmt_q;
      A_DIV: rd_data[DIV_W-1:0] = sh_div;
      A_TIM: begin
        rd_data[PER_W-1:0] = sh_per;
        rd_data[WID_LSB +: WID_W] = sh_wid;
      end
      default: ;
    endcase
  end

  // R3
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= act_div);

  // R3
  per_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_cnt <= act_per);

  // R5
  mid_period_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !bnd) |=> ($stable(act_div) && $stable(act_per) && $stable(act_wid)));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && pend && !cmt_rise) |=> !pend);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (pre_cnt == '0 && per_cnt == '0));

endmodule

// File: tb/sim_shadowed_pwm.sv
module sim_shadowed_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;
  int tests = 0;
  int fails = 0;

  localparam logic [3:0] A_EN = 4'h0, A_CMT = 4'h4, A_DIV = 4'h8, A_TIM = 4'hC;

  shadowed_pwm u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                   .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  task automatic chk_bit(input logic got, input logic exp, input string tag, input int idx);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s sample %0d: pwm_out=%0b expected %0b", tag, idx, got, exp);
    end
  endtask

  task automatic chk_word(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] tim(input int per, input int wid);
    return 32'(per) | (32'(wid) << 16);
  endfunction

  // Ends on the negedge that is sample 0 of the first enabled period.
  task automatic cfg_enable(input int dv, input int per, input int wid);
    wr(A_EN, 0);
    wr(A_DIV, 32'(dv));
    wr(A_TIM, tim(per, wid));
    wr(A_CMT, 1);
    wr(A_CMT, 0);
    wr(A_EN, 1);
  endtask

  task automatic pattern(input int h, input int p, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk_bit(pwm_out, (i % p) < h, tag, i);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk_bit(pwm_out, 1'b0, "R1 out", 0);
    rd(A_EN, d);  chk_word(d, 0, "R1 enable");
    rd(A_CMT, d); chk_word(d, 0, "R1 commit");
    rd(A_DIV, d); chk_word(d, 0, "R1 divider");
    rd(A_TIM, d); chk_word(d, 0, "R1 timing");
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, d); chk_word(d, 32'h0000_03FF, "R2 divider");
    wr(A_TIM, 32'hFFFF_FFFF); rd(A_TIM, d); chk_word(d, 32'h1FFF_0FFF, "R2 timing");
    wr(A_CMT, 32'hFFFF_FFFF); rd(A_CMT, d); chk_word(d, 32'h1, "R2 commit");
    wr(A_CMT, 0);             rd(A_CMT, d); chk_word(d, 32'h0, "R2 commit clear");
    wr(A_EN, 32'hFFFF_FFFE);  rd(A_EN, d);  chk_word(d, 32'h0, "R2 enable bit0");
    wr(A_EN, 0);
    wr(4'h2, 32'hFFFF_FFFF);  rd(4'h2, d);  chk_word(d, 32'h0, "R2 unmapped");
    rd(A_DIV, d); chk_word(d, 32'h0000_03FF, "R2 divider kept");
  endtask

  task automatic t_basic;
    cfg_enable(0, 7, 3);  pattern(3, 8, 24, "R3 div0");
    cfg_enable(2, 4, 2);  pattern(6, 15, 45, "R3 div2");
    cfg_enable(0, 0, 1);  pattern(1, 1, 6, "R7 minimal");
    cfg_enable(1, 9, 0);  pattern(0, 20, 40, "R6 width0");
    cfg_enable(3, 2, 5);  pattern(12, 12, 36, "R7 wide");
    cfg_enable(2, 4, 5);  pattern(15, 15, 30, "R7 equal");
    cfg_enable(1, 3, 4);  pattern(8, 8, 16, "R9 commit while idle");
  endtask

  // A: div1 per9 wid4 -> P=20 H=8 ; B: div2 per3 wid2 -> P=12 H=6
  task automatic t_mid_commit;
    cfg_enable(1, 9, 4);
    for (int i = 0; i < 44; i++) begin
      if (i > 0) @(negedge clk);
      chk_bit(pwm_out, (i < 20) ? (i < 8) : (((i - 20) % 12) < 6), "R5 boundary reload", i);
      wr_en = 1'b1;
      case (i)
        0: begin addr = A_DIV; wr_data = 2; end
        1: begin addr = A_TIM; wr_data = tim(3, 2); end
        2: begin addr = A_CMT; wr_data = 1; end
        3: begin addr = A_CMT; wr_data = 0; end
        default: wr_en = 1'b0;
      endcase
    end
    wr_en = 1'b0;
  endtask

  task automatic t_no_commit;
    cfg_enable(1, 9, 4);
    for (int i = 0; i < 40; i++) begin
      if (i > 0) @(negedge clk);
      chk_bit(pwm_out, (i % 20) < 8, "R4 shadow only", i);
      wr_en = 1'b1;
      case (i)
        0: begin addr = A_DIV; wr_data = 0; end
        1: begin addr = A_TIM; wr_data = tim(2, 1); end
        default: wr_en = 1'b0;
      endcase
    end
    wr_en = 1'b0;
  endtask

  task automatic t_commit_held;
    cfg_enable(1, 9, 4);
    for (int i = 0; i < 60; i++) begin
      if (i > 0) @(negedge clk);
      chk_bit(pwm_out, (i % 20) < 8, "R5 commit held high", i);
      wr_en = 1'b1;
      case (i)
        0: begin addr = A_CMT; wr_data = 1; end
        1: begin addr = A_DIV; wr_data = 0; end
        2: begin addr = A_TIM; wr_data = tim(2, 1); end
        3: begin addr = A_CMT; wr_data = 1; end
        default: wr_en = 1'b0;
      endcase
    end
    wr_en = 1'b0;
    wr(A_CMT, 0);
  endtask

  task automatic t_disable;
    cfg_enable(1, 9, 4);
    pattern(8, 20, 7, "R8 before disable");
    wr(A_EN, 0);
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      chk_bit(pwm_out, 1'b0, "R8 disabled low", i);
    end
    wr(A_EN, 1);
    pattern(8, 20, 40, "R8 restart");
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_readback();
    t_basic();
    t_mid_commit();
    t_no_commit();
    t_commit_held();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule